// File: doc/BRIEF.md
# Two-Wire Controller Register Front End

This block is the register-facing half of a two-wire serial controller. It sits on a simple peripheral bus that carries an address, a write strobe, a read strobe, an access size and 16-bit data. It holds the controller's configuration, status, interrupt and FIFO registers, plus a one-entry transmit holding register and a one-entry receive holding register. The serial engine that drives the wires is a separate block. It talks to this one through an engine port: it can pulse status bits to one, load the slave and FIFO status words, and deliver a received data word. The engine reads the transmit word from a dedicated output.

Every access is checked for size and for address. Only halfword accesses are accepted. A rejected access raises a one-cycle error strobe in the same cycle and changes nothing. A second output tells whether the rejection was for size or for address, and a size fault is reported even when the address is also bad. The status registers clear by writing ones. In the master status register only the five error bits can be cleared. The transmit and receive ports have their own read and write behaviour.

Top module: `twc_csr`

## Requirements
- R1: After reset every register reads 0x0000, and the transmit holding output `tx_hold` is 0x0000.
- R2: An access whose `bus_size` is not 1 (0 = byte, 1 = halfword, 2 = word, 3 = reserved) is rejected. In that cycle `bus_err` and `bus_err_size` are both 1, `bus_rdata` is 0, and no register changes. This applies at any address, mapped or not.
- R3: A halfword access to an offset that holds no register is rejected. This covers offsets that are not multiples of 4, offsets 0x30 to 0x7C, and offsets 0x90 and above. In that cycle `bus_err` is 1, `bus_err_size` is 0, `bus_rdata` is 0, and nothing changes.
- R4: The eight offsets 0x00, 0x04, 0x08, 0x10, 0x14, 0x1C, 0x24 and 0x28 are plain read/write registers. Each one reads back the last value written to it.
- R5: A write to the interrupt status register (0x20) clears each bit written as one and leaves bits written as zero unchanged. `eng_istat_set` sets bits.
- R6: A write to the master status register (0x18) clears only bits [4:0] written as one. Bits [15:5] are unaffected by writes. `eng_mstat_set` sets bits.
- R7: When the engine sets a status bit in the same cycle that software clears it, the bit ends up set.
- R8: Slave status (0x0C), FIFO status (0x2C) and the receive ports (0x88, 0x8C) are read-only. Writes to them raise no error and change nothing. `eng_stat_we` loads slave and FIFO status, and `eng_rx_we` loads the receive holding register.
- R9: A write to 0x80 stores `{8'h00, wdata[7:0]}` in the transmit holding register. A write to 0x84 stores all 16 bits. The result appears on `tx_hold` after the clock edge.
- R10: A read of 0x80 or 0x84 returns 0. A read of 0x88 or 0x8C returns the receive holding register.
- R11: `bus_err` is 1 only in a cycle that carries a rejected access. `bus_rdata` is 0 in every cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| bus_err | output | 1 | Rejected-access strobe |
| bus_err_size | output | 1 | Rejection was for size (1) or address (0) |
| eng_mstat_set | input | 16 | Engine pulses that set master status bits |
| eng_istat_set | input | 16 | Engine pulses that set interrupt status bits |
| eng_stat_we | input | 1 | Load slave and FIFO status |
| eng_sstat | input | 16 | Slave status value to load |
| eng_fstat | input | 16 | FIFO status value to load |
| eng_rx_we | input | 1 | Load receive holding register |
| eng_rx_data | input | 16 | Received word |
| tx_hold | output | 16 | Transmit holding register |

## Verification
The bench sweeps all 256 offsets at every access size.
- A decoder that misses the gap, or accepts misaligned offsets, would answer where it should raise an error.
- A design that checks the address before the size would report an address fault for a wrong-size access to an unmapped offset.
- Wrong-size and unmapped writes that leak into registers show up when the bench reads the registers back afterwards.
- A master-status clear that ignores the mask would wipe the upper bits the engine set.
- If clear wins over set, an event that arrives in the same cycle as the clear is lost.
- If the byte transmit port fails to zero the upper byte, stale data shows on `tx_hold`.

// File: rtl/twc_csr.sv
module twc_csr #(
  parameter int AW = 8,
  parameter logic [15:0] MSTAT_CLR_MASK = 16'h001F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_size,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          bus_err,
  output logic          bus_err_size,
  input  logic [15:0]   eng_mstat_set,
  input  logic [15:0]   eng_istat_set,
  input  logic          eng_stat_we,
  input  logic [15:0]   eng_sstat,
  input  logic [15:0]   eng_fstat,
  input  logic          eng_rx_we,
  input  logic [15:0]   eng_rx_data,
  output logic [15:0]   tx_hold
);
  localparam int NCFG = 8;

  logic [15:0] cfg [NCFG];
  logic [15:0] sstat, fstat, mstat, istat, rxh;

  logic [7:0] widx;
  logic       mapped, cfg_hit, is_ms, is_is, is_tx8, is_tx16;
  logic [2:0] cfg_sel;
  logic [15:0] rval;

  assign widx = 8'(bus_addr[AW-1:2]);

  always_comb begin
    mapped = 1'b0; cfg_hit = 1'b0; cfg_sel = 3'd0;
    is_ms = 1'b0; is_is = 1'b0; is_tx8 = 1'b0; is_tx16 = 1'b0;
    rval = 16'h0000;
    if (bus_addr[1:0] == 2'b00) begin
      mapped = 1'b1;
      case (widx)
        8'h00: begin cfg_hit = 1'b1; cfg_sel = 3'd0; end
        8'h01: begin cfg_hit = 1'b1; cfg_sel = 3'd1; end
        8'h02: begin cfg_hit = 1'b1; cfg_sel = 3'd2; end
        8'h03: rval = sstat;
        8'h04: begin cfg_hit = 1'b1; cfg_sel = 3'd3; end
        8'h05: begin cfg_hit = 1'b1; cfg_sel = 3'd4; end
        8'h06: begin is_ms = 1'b1; rval = mstat; end
        8'h07: begin cfg_hit = 1'b1; cfg_sel = 3'd5; end
        8'h08: begin is_is = 1'b1; rval = istat; end
        8'h09: begin cfg_hit = 1'b1; cfg_sel = 3'd6; end
        8'h0A: begin cfg_hit = 1'b1; cfg_sel = 3'd7; end
        8'h0B: rval = fstat;
        8'h20: is_tx8 = 1'b1;
        8'h21: is_tx16 = 1'b1;
        8'h22, 8'h23: rval = rxh;
        default: mapped = 1'b0;
      endcase
      if (cfg_hit) rval = cfg[cfg_sel];
    end
  end

  wire acc     = bus_wr | bus_rd;
  wire size_ok = (bus_size == 2'd1);
  wire ok      = acc & size_ok & mapped;
  wire wr_ok   = bus_wr & ok;

  assign bus_err      = acc & ~(size_ok & mapped);
  assign bus_err_size = acc & ~size_ok;
  assign bus_rdata    = (bus_rd & ok) ? rval : 16'h0000;

  wire [15:0] ms_clr = (wr_ok & is_ms) ? (bus_wdata & MSTAT_CLR_MASK) : 16'h0000;
  wire [15:0] is_clr = (wr_ok & is_is) ? bus_wdata : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) cfg[i] <= 16'h0000;
      sstat <= '0; fstat <= '0; mstat <= '0; istat <= '0;
      rxh <= '0; tx_hold <= '0;
    end else begin
      if (wr_ok & cfg_hit) cfg[cfg_sel] <= bus_wdata;
      mstat <= (mstat & ~ms_clr) | eng_mstat_set;
      istat <= (istat & ~is_clr) | eng_istat_set;
      if (eng_stat_we) begin
        sstat <= eng_sstat;
        fstat <= eng_fstat;
      end
      if (eng_rx_we) rxh <= eng_rx_data;
      if (wr_ok & is_tx8)  tx_hold <= {8'h00, bus_wdata[7:0]};
      if (wr_ok & is_tx16) tx_hold <= bus_wdata;
    end
  end
endmodule

module twc_csr_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_size,
  input logic [15:0]   bus_rdata,
  input logic          bus_err,
  input logic          bus_err_size,
  input logic [15:0]   eng_mstat_set,
  input logic [15:0]   mstat,
  input logic [15:0]   tx_hold
);
  // R2
  size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr | bus_rd) && bus_size != 2'd1) |-> (bus_err && bus_err_size));
  // R3
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr | bus_rd) && bus_size == 2'd1 && bus_addr[1:0] != 2'b00) |-> (bus_err && !bus_err_size));
  // R11
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_err) |-> (bus_rdata == 16'h0000));
  // R11
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr | bus_rd) |-> !bus_err);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_mstat_set) |=> ((mstat & $past(eng_mstat_set)) == $past(eng_mstat_set)));
  // R9
  tx8_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 2'd1 && bus_addr == AW'('h80)) |=> (tx_hold[15:8] == 8'h00));
endmodule

bind twc_csr twc_csr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_size(bus_size), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .bus_err_size(bus_err_size), .eng_mstat_set(eng_mstat_set), .mstat(mstat),
  .tx_hold(tx_hold)
);

// File: tb/tb_twc_csr.sv
module tb_twc_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err, bus_err_size;
  logic [15:0] eng_mstat_set = '0, eng_istat_set = '0;
  logic        eng_stat_we = 1'b0, eng_rx_we = 1'b0;
  logic [15:0] eng_sstat = '0, eng_fstat = '0, eng_rx_data = '0;
  logic [15:0] tx_hold;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twc_csr dut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [15:0] r_data;
  logic r_err, r_esz;

  task automatic access(bit wr, logic [7:0] a, logic [1:0] sz, logic [15:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    #2;
    r_data = bus_rdata; r_err = bus_err; r_esz = bus_err_size;
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0;
  endtask

  function automatic bit mapped(int a);
    return (a % 4 == 0) && (a < 'h30 || (a >= 'h80 && a < 'h90));
  endfunction

  function automatic bit is_cfg(int a);
    return a == 'h00 || a == 'h04 || a == 'h08 || a == 'h10 ||
           a == 'h14 || a == 'h1C || a == 'h24 || a == 'h28;
  endfunction

  function automatic logic [15:0] pat(int a);
    return 16'hA5C3 ^ (16'(a) * 16'h0101);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state and R3 decode sweep
    check("R1 tx_hold", tx_hold, 16'h0000);
    for (int a = 0; a < 256; a++) begin
      access(0, 8'(a), 2'd1, 16'h0);
      check("R3 err", 16'(r_err), 16'(!mapped(a)));
      check("R3 errsize", 16'(r_esz), 16'h0);
      check("R1 rdata", r_data, 16'h0000);
      #2 check("R11 idle err", 16'(bus_err), 16'h0);
      check("R11 idle rdata", bus_rdata, 16'h0000);
    end
    // R4 plain registers
    for (int a = 0; a < 'h30; a += 4)
      if (is_cfg(a)) access(1, 8'(a), 2'd1, pat(a));
    // R2 wrong size everywhere, writes and reads
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++)
        if (s != 1) begin
          access(1, 8'(a), 2'(s), 16'hFFFF);
          check("R2 err", {14'h0, r_err, r_esz}, 16'h0003);
          access(0, 8'(a), 2'(s), 16'h0);
          check("R2 rd err", {14'h0, r_err, r_esz}, 16'h0003);
          check("R2 rdata", r_data, 16'h0000);
        end
    // R3 unmapped halfword writes
    for (int a = 0; a < 256; a++)
      if (!mapped(a)) begin
        access(1, 8'(a), 2'd1, 16'hFFFF);
        check("R3 wr err", {14'h0, r_err, r_esz}, 16'h0002);
      end
    for (int a = 0; a < 'h30; a += 4) begin
      access(0, 8'(a), 2'd1, 16'h0);
      check("R4 readback", r_data, is_cfg(a) ? pat(a) : 16'h0000);
    end
    check("R2 tx untouched", tx_hold, 16'h0000);
    // R5 interrupt status
    eng_istat_set = 16'hFFFF; @(posedge clk); #1 eng_istat_set = 0;
    access(1, 8'h20, 2'd1, 16'h00F0);
    access(0, 8'h20, 2'd1, 16'h0);
    check("R5 istat", r_data, 16'hFF0F);
    // R6 master status
    eng_mstat_set = 16'hFFFF; @(posedge clk); #1 eng_mstat_set = 0;
    access(1, 8'h18, 2'd1, 16'hFFFF);
    access(0, 8'h18, 2'd1, 16'h0);
    check("R6 mstat", r_data, 16'hFFE0);
    // R7 set beats clear
    eng_mstat_set = 16'h0003;
    access(1, 8'h18, 2'd1, 16'h0003);
    eng_mstat_set = 0;
    access(0, 8'h18, 2'd1, 16'h0);
    check("R7 mstat", r_data, 16'hFFE3);
    access(1, 8'h18, 2'd1, 16'h0003);
    access(0, 8'h18, 2'd1, 16'h0);
    check("R6 mstat clear", r_data, 16'hFFE0);
    eng_istat_set = 16'h0100;
    access(1, 8'h20, 2'd1, 16'h0100);
    eng_istat_set = 0;
    access(0, 8'h20, 2'd1, 16'h0);
    check("R7 istat", r_data, 16'hFF0F);
    // R8 read-only
    eng_stat_we = 1; eng_sstat = 16'h1234; eng_fstat = 16'h5678;
    eng_rx_we = 1; eng_rx_data = 16'hBEEF;
    @(posedge clk); #1 eng_stat_we = 0; eng_rx_we = 0;
    access(1, 8'h0C, 2'd1, 16'hFFFF); check("R8 no err", 16'(r_err), 16'h0);
    access(1, 8'h2C, 2'd1, 16'hFFFF); check("R8 no err", 16'(r_err), 16'h0);
    access(1, 8'h88, 2'd1, 16'h0000); check("R8 no err", 16'(r_err), 16'h0);
    access(1, 8'h8C, 2'd1, 16'h0000); check("R8 no err", 16'(r_err), 16'h0);
    access(0, 8'h0C, 2'd1, 16'h0); check("R8 sstat", r_data, 16'h1234);
    access(0, 8'h2C, 2'd1, 16'h0); check("R8 fstat", r_data, 16'h5678);
    // R10 receive and transmit reads
    access(0, 8'h88, 2'd1, 16'h0); check("R10 rx8", r_data, 16'hBEEF);
    access(0, 8'h8C, 2'd1, 16'h0); check("R10 rx16", r_data, 16'hBEEF);
    // R9 transmit writes
    access(1, 8'h84, 2'd1, 16'hABCD); check("R9 tx16", tx_hold, 16'hABCD);
    access(1, 8'h80, 2'd1, 16'h1234); check("R9 tx8", tx_hold, 16'h0034);
    access(0, 8'h80, 2'd1, 16'h0); check("R10 tx8 read", r_data, 16'h0000);
    access(0, 8'h84, 2'd1, 16'h0); check("R10 tx16 read", r_data, 16'h0000);
    access(1, 8'h84, 2'd0, 16'hFFFF); check("R2 tx size", tx_hold, 16'h0034);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule